// File: doc/BRIEF.md
# 40-Column Text Line Generator

This block produces the pixel stream for one scanline of a 40-column text display in a tile-based video controller. At the start of each line it decides whether the line is displayed. If it is, the block walks across the 40 character positions. For each position it reads a character code from the name table in video memory, then the matching pattern byte for the current scanline. It shifts out six pixels per character. Each pixel is coloured from the two nibbles of a colour register; no per-character colour data is read.

The surrounding controller supplies a free-running pixel counter (0 at the start of each line) and a line counter. It also supplies the mode select and the colour register, and serves a simple read port into video memory with one cycle of read latency. The block returns a 4-bit colour index and a blank flag for each pixel position. A line shows 240 lit pixels. The last 16 positions of the 256-pixel window are always forced to blank, so nothing left over from an earlier line can leak through.

Top module: `txt40_linegen`

## Requirements
- R1: While reset is held and in the cycle after it, pix_blank_o is 1, pix_colour_o is 0 and vram_rd_o is 0.
- R2: On a displayed line the block issues exactly 80 reads, two per character, never in back-to-back cycles. The first read of each character goes to NAME_BASE + (line_y_i / 8) * COLS + column, with columns taken in order 0 to 39.
- R3: The second read of each character goes to PAT_BASE + name * 8 + (line_y_i mod 8), where name is the byte returned by the first read.
- R4: Screen pixel p (0 to 239) belongs to character p / 6 and shows bit 7 - (p mod 6) of its pattern byte, so pattern bits 7 down to 2 appear in that order and bits 1 and 0 never appear. Pixel p is on the outputs in the cycle after the one in which pix_x_i equals p + 7.
- R5: A pattern bit of 1 shows colour_reg_i[7:4] and a bit of 0 shows colour_reg_i[3:0]. When colour_reg_i[7:4] is 0, a 1 bit shows colour_reg_i[3:0] instead.
- R6: Screen pixels 240 to 255, and every position outside the 256-pixel window, have pix_blank_o = 1 and pix_colour_o = 0.
- R7: If text_en_i is 0, or line_y_i is ACTIVE_LINES or more, when pix_x_i is 0, the whole line is blank and no read is issued.
- R8: The 240 pixels of a displayed line come out with no gap. Blank falls only at pixel 0 and rises only at pixel 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_x_i | input | PX_W | Pixel counter, 0 at line start |
| line_y_i | input | LY_W | Scanline counter, held for the line |
| text_en_i | input | 1 | Text mode select, sampled at pixel 0 |
| colour_reg_i | input | 8 | Colour register: [7:4] foreground, [3:0] background |
| vram_rd_o | output | 1 | Video memory read request |
| vram_addr_o | output | AW | Video memory read address |
| vram_data_i | input | 8 | Read data, valid the cycle after the request |
| pix_colour_o | output | 4 | Colour index of the current pixel |
| pix_blank_o | output | 1 | Pixel is blanked |

## Verification
On every cycle the assertions check several properties. Reads never come in adjacent cycles, and an idle line issues none. A new pattern is loaded only when the previous cell has fully drained. Blank edges fall only at pixel 0 and rise only at pixel 240, the 16-pixel tail is always blank, and blanked pixels carry colour 0. Only the bench's line scenarios can show the values themselves. These are the name and pattern addresses, the order of pattern bits within a cell, the foreground/background choice with its zero-foreground substitution, and the read count per line. The bench compares these against a model of video memory content that changes from line to line.

// File: rtl/txt40_pkg.sv
package txt40_pkg;

    // Pattern bytes are 8 bits; the counter starts at CELL_SKIP so only bits 7..2 show.
    localparam int PAT_BITS  = 8;
    localparam int CELL_SKIP = 2;
    localparam int CELL_W    = PAT_BITS - CELL_SKIP;

    // One character slot of the fetch sequence, CELL_W cycles long.
    typedef enum logic [2:0] {
        PH_NAME      = 3'd0,
        PH_NAME_WAIT = 3'd1,
        PH_PAT       = 3'd2,
        PH_PAT_WAIT  = 3'd3,
        PH_HOLD      = 3'd4,
        PH_LOAD      = 3'd5
    } fetch_ph_e;

    typedef struct packed {
        logic [3:0] fg;
        logic [3:0] bg;
    } colour_reg_t;

    function automatic fetch_ph_e next_phase(fetch_ph_e ph);
        case (ph)
            PH_NAME:      return PH_NAME_WAIT;
            PH_NAME_WAIT: return PH_PAT;
            PH_PAT:       return PH_PAT_WAIT;
            PH_PAT_WAIT:  return PH_HOLD;
            PH_HOLD:      return PH_LOAD;
            default:      return PH_NAME;
        endcase
    endfunction

    // A zero foreground falls back to the background colour.
    function automatic logic [3:0] pick_colour(logic bit_on, colour_reg_t r);
        if (bit_on && (r.fg != 4'd0))
            return r.fg;
        return r.bg;
    endfunction

endpackage

// File: rtl/txt40_fetch.sv
module txt40_fetch
    import txt40_pkg::*;
#(
    parameter int AW           = 14,
    parameter int PX_W         = 9,
    parameter int LY_W         = 8,
    parameter int COLS         = 40,
    parameter int ACTIVE_LINES = 192,
    parameter logic [AW-1:0] NAME_BASE = 14'h0800,
    parameter logic [AW-1:0] PAT_BASE  = 14'h0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PX_W-1:0] pix_x_i,
    input  logic [LY_W-1:0] line_y_i,
    input  logic            text_en_i,
    output logic            rd_o,
    output logic [AW-1:0]   addr_o,
    input  logic [7:0]      data_i,
    output logic            load_o,
    output logic [7:0]      pat_o
);
    localparam int CW = $clog2(COLS);
    localparam logic [CW-1:0] LAST_COL = CW'(COLS - 1);

    logic            run_q;
    fetch_ph_e       ph_q;
    logic [CW-1:0]   col_q;
    logic [AW-1:0]   rowbase_q;
    logic [2:0]      sub_q;
    logic [7:0]      name_q;
    logic [7:0]      pat_q;

    logic line_start;
    logic line_shown;
    assign line_start = (pix_x_i == '0);
    assign line_shown = text_en_i && (int'(line_y_i) < ACTIVE_LINES);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q     <= 1'b0;
            ph_q      <= PH_NAME;
            col_q     <= '0;
            rowbase_q <= '0;
            sub_q     <= '0;
            name_q    <= '0;
            pat_q     <= '0;
        end else if (line_start) begin
            run_q     <= line_shown;
            ph_q      <= PH_NAME;
            col_q     <= '0;
            rowbase_q <= NAME_BASE + AW'(line_y_i[LY_W-1:3]) * AW'(COLS);
            sub_q     <= line_y_i[2:0];
        end else if (run_q) begin
            ph_q <= next_phase(ph_q);
            case (ph_q)
                PH_NAME_WAIT: name_q <= data_i;
                PH_PAT_WAIT:  pat_q  <= data_i;
                PH_LOAD: begin
                    if (col_q == LAST_COL)
                        run_q <= 1'b0;
                    else
                        col_q <= col_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        rd_o   = run_q && ((ph_q == PH_NAME) || (ph_q == PH_PAT));
        if (ph_q == PH_NAME)
            addr_o = rowbase_q + AW'(col_q);
        else
            addr_o = PAT_BASE + (AW'(name_q) << 3) + AW'(sub_q);
        load_o = run_q && (ph_q == PH_LOAD);
        pat_o  = pat_q;
    end

    // R2: the two reads of a slot are never issued in adjacent cycles
    a_r2_read_spacing: assert property (@(posedge clk) disable iff (rst)
        rd_o |=> !rd_o);

    // R7: a line that is not shown starts no reads
    a_r7_idle_no_read: assert property (@(posedge clk) disable iff (rst)
        (line_start && !line_shown) |=> !rd_o);

endmodule

// File: rtl/txt40_shifter.sv
module txt40_shifter
    import txt40_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load_i,
    input  logic [7:0] pat_i,
    output logic       bit_o,
    output logic       vld_o
);
    localparam logic [2:0] BC_FIRST = 3'(CELL_SKIP);
    localparam logic [2:0] BC_LAST  = 3'(PAT_BITS - 1);

    logic [7:0] sh_q;
    logic [2:0] bc_q;
    logic       vld_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= '0;
            bc_q  <= BC_LAST;
            vld_q <= 1'b0;
        end else if (load_i) begin
            sh_q  <= pat_i;
            bc_q  <= BC_FIRST;
            vld_q <= 1'b1;
        end else if (bc_q != BC_LAST) begin
            sh_q <= {sh_q[6:0], 1'b0};
            bc_q <= bc_q + 1'b1;
        end else begin
            vld_q <= 1'b0;
        end
    end

    assign bit_o = sh_q[7];
    assign vld_o = vld_q;

    // R4: a new cell arrives only once the current one has shown its last pixel
    a_r4_load_boundary: assert property (@(posedge clk) disable iff (rst)
        load_i |-> (!vld_q || (bc_q == BC_LAST)));

endmodule

// File: rtl/txt40_pixout.sv
module txt40_pixout
    import txt40_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       bit_i,
    input  logic       vld_i,
    input  logic [7:0] colour_reg_i,
    output logic [3:0] colour_o,
    output logic       blank_o
);
    colour_reg_t creg;
    assign creg = colour_reg_t'(colour_reg_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            colour_o <= '0;
            blank_o  <= 1'b1;
        end else begin
            colour_o <= vld_i ? pick_colour(bit_i, creg) : 4'd0;
            blank_o  <= !vld_i;
        end
    end

    // R6: a blanked pixel never carries a colour
    a_r6_blank_colour: assert property (@(posedge clk) disable iff (rst)
        blank_o |-> (colour_o == 4'd0));

endmodule

// File: rtl/txt40_linegen.sv
module txt40_linegen
    import txt40_pkg::*;
#(
    parameter int AW           = 14,
    parameter int PX_W         = 9,
    parameter int LY_W         = 8,
    parameter int COLS         = 40,
    parameter int ACTIVE_LINES = 192,
    parameter logic [AW-1:0] NAME_BASE = 14'h0800,
    parameter logic [AW-1:0] PAT_BASE  = 14'h0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PX_W-1:0] pix_x_i,
    input  logic [LY_W-1:0] line_y_i,
    input  logic            text_en_i,
    input  logic [7:0]      colour_reg_i,
    output logic            vram_rd_o,
    output logic [AW-1:0]   vram_addr_o,
    input  logic [7:0]      vram_data_i,
    output logic [3:0]      pix_colour_o,
    output logic            pix_blank_o
);
    // Pixel p is visible the cycle after pix_x_i == p + LEAD.
    localparam int LEAD       = 7;
    localparam int TAIL_START = COLS * CELL_W + LEAD;
    localparam int WIN_END    = 256 + LEAD;

    logic       load;
    logic [7:0] pat;
    logic       sh_bit;
    logic       sh_vld;

    txt40_fetch #(
        .AW(AW), .PX_W(PX_W), .LY_W(LY_W), .COLS(COLS),
        .ACTIVE_LINES(ACTIVE_LINES), .NAME_BASE(NAME_BASE), .PAT_BASE(PAT_BASE)
    ) u_fetch (
        .clk(clk), .rst(rst), .pix_x_i(pix_x_i), .line_y_i(line_y_i),
        .text_en_i(text_en_i), .rd_o(vram_rd_o), .addr_o(vram_addr_o),
        .data_i(vram_data_i), .load_o(load), .pat_o(pat)
    );

    txt40_shifter u_shift (
        .clk(clk), .rst(rst), .load_i(load), .pat_i(pat),
        .bit_o(sh_bit), .vld_o(sh_vld)
    );

    txt40_pixout u_out (
        .clk(clk), .rst(rst), .bit_i(sh_bit), .vld_i(sh_vld),
        .colour_reg_i(colour_reg_i), .colour_o(pix_colour_o), .blank_o(pix_blank_o)
    );

    // R6: the 16 positions after the last character are always blank
    a_r6_tail_blank: assert property (@(posedge clk) disable iff (rst)
        ((int'($past(pix_x_i)) >= TAIL_START) && (int'($past(pix_x_i)) < WIN_END))
        |-> pix_blank_o);

    // R8: lit run starts exactly at pixel 0
    a_r8_fall_point: assert property (@(posedge clk) disable iff (rst)
        $fell(pix_blank_o) |-> (int'($past(pix_x_i)) == LEAD));

    // R8: lit run ends exactly after pixel 239
    a_r8_rise_point: assert property (@(posedge clk) disable iff (rst)
        $rose(pix_blank_o) |-> (int'($past(pix_x_i)) == TAIL_START));

endmodule

// File: tb/txt40_linegen_tb.sv
module txt40_linegen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PIX_TOTAL  = 342;
    localparam int AW         = 14;
    localparam int NB         = 14'h0800;
    localparam int PB         = 14'h0000;
    localparam int LEAD       = 7;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [8:0]    pix_x = '0;
    logic [7:0]    line_y = '0;
    logic          text_en = 1'b0;
    logic [7:0]    creg = '0;
    logic          vram_rd;
    logic [AW-1:0] vram_addr;
    logic [7:0]    vram_data = '0;
    logic [3:0]    colour;
    logic          blank;

    int total = 0;
    int bad = 0;
    int salt = 0;
    int rd_cnt = 0;
    int first_addr = 0;
    int second_addr = 0;
    bit cur_shown = 1'b0;
    int cur_y = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txt40_linegen u_dut (
        .clk(clk), .rst(rst), .pix_x_i(pix_x), .line_y_i(line_y),
        .text_en_i(text_en), .colour_reg_i(creg), .vram_rd_o(vram_rd),
        .vram_addr_o(vram_addr), .vram_data_i(vram_data),
        .pix_colour_o(colour), .pix_blank_o(blank)
    );

    function automatic logic [7:0] mem_byte(int a, int s);
        return 8'((a * 37) ^ (a >> 3) ^ (s * 13) ^ (a >> 9));
    endfunction

    // video memory model: one cycle of read latency
    always @(posedge clk) begin
        if (vram_rd) begin
            if (rd_cnt == 0) first_addr = int'(vram_addr);
            if (rd_cnt == 1) second_addr = int'(vram_addr);
            rd_cnt = rd_cnt + 1;
            vram_data <= mem_byte(int'(vram_addr), salt);
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // expected output while pix_x holds pv, for the current line settings
    task automatic check_pixel(int pv);
        int p;
        int c;
        int j;
        logic [7:0] nm;
        logic [7:0] pt;
        logic       b;
        logic [3:0] fg;
        logic [3:0] bg;
        logic [3:0] ec;
        p = pv - LEAD;
        if (cur_shown && p >= 0 && p < 240) begin
            c  = p / 6;
            j  = p % 6;
            nm = mem_byte(NB + (cur_y / 8) * 40 + c, salt);
            pt = mem_byte(PB + int'(nm) * 8 + (cur_y % 8), salt);
            b  = pt[7 - j];
            fg = creg[7:4];
            bg = creg[3:0];
            ec = (b && fg != 0) ? fg : bg;
            check(blank == 1'b0, "R8 lit pixel", int'(blank), 0);
            check(colour == ec, "R4 R5 pixel colour", int'(colour), int'(ec));
        end else begin
            check(blank == 1'b1 && colour == 4'd0,
                  (p >= 240 && p < 256) ? "R6 tail blank" : (cur_shown ? "R6 edge blank" : "R7 line blank"),
                  {27'd0, blank, colour}, 32'h10);
        end
    endtask

    task automatic run_line(int y, bit en, logic [7:0] cr, int s);
        for (int v = 0; v < PIX_TOTAL; v++) begin
            @(negedge clk);
            check_pixel(int'(pix_x));
            if (v == 0) begin
                line_y    = 8'(y);
                text_en   = en;
                creg      = cr;
                salt      = s;
                rd_cnt    = 0;
                cur_y     = y;
                cur_shown = en && (y < 192);
            end
            pix_x = 9'(v);
        end
        // reads have all finished by now
        if (cur_shown) begin
            check(rd_cnt == 80, "R2 read count", rd_cnt, 80);
            check(first_addr == NB + (y / 8) * 40, "R2 name address", first_addr, NB + (y / 8) * 40);
            check(second_addr == PB + int'(mem_byte(NB + (y / 8) * 40, s)) * 8 + (y % 8),
                  "R3 pattern address", second_addr,
                  PB + int'(mem_byte(NB + (y / 8) * 40, s)) * 8 + (y % 8));
        end else begin
            check(rd_cnt == 0, "R7 no reads", rd_cnt, 0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        check(blank == 1'b1 && colour == 4'd0 && vram_rd == 1'b0, "R1 in reset",
              {27'd0, vram_rd, blank, colour}, 32'h10);
        rst = 1'b0;
        @(negedge clk);
        check(blank == 1'b1 && colour == 4'd0 && vram_rd == 1'b0, "R1 after reset",
              {27'd0, vram_rd, blank, colour}, 32'h10);

        run_line(0,   1'b1, 8'hF4, 0);
        run_line(7,   1'b1, 8'h1E, 1);
        run_line(8,   1'b1, 8'h0A, 2);   // R5 zero foreground
        run_line(13,  1'b1, 8'h50, 3);
        run_line(100, 1'b1, 8'h35, 4);
        run_line(191, 1'b1, 8'hC2, 5);   // last displayed row
        run_line(192, 1'b1, 8'hF4, 6);   // R7 beyond active lines
        run_line(50,  1'b0, 8'hF4, 7);   // R7 mode off
        run_line(255, 1'b1, 8'h7B, 8);
        for (int y = 1; y < 192; y += 11)
            run_line(y, 1'b1, 8'(y * 7 + 1), y + 20);
        run_line(60,  1'b0, 8'h11, 9);   // flush tail of the last displayed line

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule